// File: doc/BRIEF.md
# Hardware Loop Unit

This block removes the branch overhead of counted loops in a simple in-order fetch stage. It holds three registers: the address where the loop body begins, the address just past the body, and the number of loop-backs still to take. Every cycle it takes the current fetch address and the length of the instruction there. It then returns the address to fetch next: the start of the body when sequential flow is about to leave the body and loop-backs remain, a branch target when a branch is taken, or the sequential address otherwise.

A loop is opened with a setup command. The command carries a count operand, the body length in bytes and one of three variants. Software may also write any of the three registers directly. Together with an exception-mode flag that stops all loop-backs, these writes let software handle interrupted or hand-built loops.

Top module: `hw_loop_unit`

## Requirements
- R1: After reset all three registers read zero, and with no setup, branch or loop-back pending, `nextPc` equals `pc + instLen`.
- R2: A setup command at address P (length L, body length B) loads start = P+L, end = P+L+B and count = operand-1, so that an operand of 0 loads 0xFFFFFFFF. Variant code 0 (and the unused code 3) never skips.
- R3: When `pc + instLen` equals the end register, the count is nonzero, no branch is taken and exception mode is off, `nextPc` is the start register, `loopBack` is high, and the count drops by one on the same edge. An operand of N therefore runs the body N times.
- R4: When the count is zero at the end address, `nextPc` is sequential and the count stays zero.
- R5: A taken branch sets `nextPc` to `branchTarget`, even at the end address, and it leaves the count unchanged, so a branch out of the body ends the loop at once.
- R6: While `excMode` is high, no loop-back happens and the count is unchanged, so the body runs once.
- R7: Variant code 1 (skip-if-zero) with an operand of 0 sets `nextPc` to the new end address and still loads the registers as in R2.
- R8: Variant code 2 (skip-if-not-positive) reads the operand as signed. When the operand is 0 or negative, including 0x80000000, `nextPc` is the new end address.
- R9: A direct register write lands on the next edge whether or not `instValid` is high, and it wins over a same-cycle setup load or decrement. A count written as C followed by entry into the body gives C+1 runs of the body.
- R10: Rewriting the start or end register while inside the loop changes every later loop-back decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction at `pc` advances this cycle |
| pc | input | AW | Address of the current instruction |
| instLen | input | LW | Length in bytes of the current instruction |
| branchTaken | input | 1 | The current instruction is a taken branch or jump |
| branchTarget | input | AW | Target of the taken branch |
| excMode | input | 1 | Exception-mode status flag; blocks loop-back |
| setupValid | input | 1 | The current instruction is a loop setup |
| setupKind | input | 2 | Setup variant: 0 always, 1 skip-if-zero, 2 skip-if-not-positive |
| setupCount | input | CW | Count operand of the setup |
| bodyLen | input | AW | Body length in bytes for the setup |
| wrStart | input | 1 | Write `wrAddr` into the start register |
| wrEnd | input | 1 | Write `wrAddr` into the end register |
| wrCount | input | 1 | Write `wrCountData` into the count register |
| wrAddr | input | AW | Data for start/end register writes |
| wrCountData | input | CW | Data for count register writes |
| nextPc | output | AW | Address to fetch next |
| loopBack | output | 1 | A loop-back redirect happens this cycle |
| loopStart | output | AW | Start register |
| loopEnd | output | AW | End register |
| loopCount | output | CW | Remaining loop-backs register |

## Verification
The bench feeds back its own predicted `nextPc` as the next `pc`, so every loop runs as a real instruction stream and the number of body executions is counted. Each case targets a specific fault:
- Operand 0 under the always variant: a design that treated it as "no loop" would show a zero count instead of the wrap to all ones.
- 0x80000000 under skip-if-not-positive: an unsigned or magnitude compare would enter the body.
- Branch at the end address: a design that checked the end before the branch would redirect to the start.
- A count write in the same cycle as a decrement: wrong priority would leave the value off by one.
- Rewriting the end mid-loop: a design that latched the end address at setup would keep looping.

// File: rtl/hw_loop_pkg.sv
package hw_loop_pkg;

  typedef enum logic [1:0] {
    KIND_ALWAYS   = 2'd0,
    KIND_NONZERO  = 2'd1,
    KIND_POSITIVE = 2'd2,
    KIND_SPARE    = 2'd3
  } setupKind_e;

  typedef struct packed {
    logic loadSetup;
    logic decCount;
    logic selStart;
    logic selEnd;
    logic selTarget;
  } loopStrobes_t;

endpackage

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
  import hw_loop_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic          branchTaken,
  input  logic          excMode,
  input  logic          setupValid,
  input  logic [1:0]    setupKind,
  input  logic [CW-1:0] setupCount,
  input  logic          atEnd,
  input  logic          countNonZero,
  output loopStrobes_t  str
);

  logic opZero;
  logic opNotPos;
  logic skipBody;

  assign opZero   = (setupCount == '0);
  assign opNotPos = setupCount[CW-1] | opZero;

  always_comb begin
    unique case (setupKind_e'(setupKind))
      KIND_NONZERO:  skipBody = opZero;
      KIND_POSITIVE: skipBody = opNotPos;
      default:       skipBody = 1'b0;
    endcase
  end

  always_comb begin
    str = '0;
    if (instValid) begin
      if (branchTaken) begin
        str.selTarget = 1'b1;
      end else if (setupValid) begin
        str.loadSetup = 1'b1;
        str.selEnd    = skipBody;
      end else if (atEnd && countNonZero && !excMode) begin
        str.selStart = 1'b1;
        str.decCount = 1'b1;
      end
    end
  end

  // only one redirect source may be chosen in a cycle
  assert_one_redirect_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.selStart, str.selEnd, str.selTarget}));

  // exception mode must never let a loop-back through
  assert_exc_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    excMode |-> !str.selStart);

endmodule

// File: rtl/hw_loop_regs.sv
module hw_loop_regs
  import hw_loop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] instLen,
  input  logic [AW-1:0] branchTarget,
  input  logic [AW-1:0] bodyLen,
  input  logic [CW-1:0] setupCount,
  input  logic          wrStart,
  input  logic          wrEnd,
  input  logic          wrCount,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrCountData,
  input  loopStrobes_t  str,
  output logic [AW-1:0] nextPc,
  output logic          atEnd,
  output logic          countNonZero,
  output logic [AW-1:0] loopStart,
  output logic [AW-1:0] loopEnd,
  output logic [CW-1:0] loopCount
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] startQ, endQ;
  logic [CW-1:0] countQ;
  logic [AW-1:0] seqPc;
  logic [AW-1:0] setupEnd;

  assign seqPc        = pc + AW'(instLen);
  assign setupEnd     = seqPc + bodyLen;
  assign atEnd        = (seqPc == endQ);
  assign countNonZero = (countQ != '0);

  always_comb begin
    if (str.selTarget)     nextPc = branchTarget;
    else if (str.selEnd)   nextPc = setupEnd;
    else if (str.selStart) nextPc = startQ;
    else                   nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      endQ   <= '0;
      countQ <= '0;
    end else begin
      if (wrStart)            startQ <= wrAddr;
      else if (str.loadSetup) startQ <= seqPc;

      if (wrEnd)              endQ <= wrAddr;
      else if (str.loadSetup) endQ <= setupEnd;

      if (wrCount)            countQ <= wrCountData;
      else if (str.loadSetup) countQ <= setupCount - ONE;
      else if (str.decCount)  countQ <= countQ - ONE;
    end
  end

  assign loopStart = startQ;
  assign loopEnd   = endQ;
  assign loopCount = countQ;

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> countQ == $past(wrCountData));

  assert_setup_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadSetup && !wrCount) |=> countQ == $past(setupCount) - ONE);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (str.decCount && !wrCount) |=> countQ == $past(countQ) - ONE);

  assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && !wrCount && !str.loadSetup) |=> countQ == '0);

  assert_branch_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.selTarget |-> nextPc == branchTarget);

endmodule

// File: rtl/hw_loop_unit.sv
module hw_loop_unit
  import hw_loop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] instLen,
  input  logic          branchTaken,
  input  logic [AW-1:0] branchTarget,
  input  logic          excMode,
  input  logic          setupValid,
  input  logic [1:0]    setupKind,
  input  logic [CW-1:0] setupCount,
  input  logic [AW-1:0] bodyLen,
  input  logic          wrStart,
  input  logic          wrEnd,
  input  logic          wrCount,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrCountData,
  output logic [AW-1:0] nextPc,
  output logic          loopBack,
  output logic [AW-1:0] loopStart,
  output logic [AW-1:0] loopEnd,
  output logic [CW-1:0] loopCount
);

  loopStrobes_t str;
  logic atEnd;
  logic countNonZero;

  hw_loop_ctrl #(.CW(CW)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .instValid    (instValid),
    .branchTaken  (branchTaken),
    .excMode      (excMode),
    .setupValid   (setupValid),
    .setupKind    (setupKind),
    .setupCount   (setupCount),
    .atEnd        (atEnd),
    .countNonZero (countNonZero),
    .str          (str)
  );

  hw_loop_regs #(.AW(AW), .CW(CW), .LW(LW)) i_regs (
    .clk          (clk),
    .rstN         (rstN),
    .pc           (pc),
    .instLen      (instLen),
    .branchTarget (branchTarget),
    .bodyLen      (bodyLen),
    .setupCount   (setupCount),
    .wrStart      (wrStart),
    .wrEnd        (wrEnd),
    .wrCount      (wrCount),
    .wrAddr       (wrAddr),
    .wrCountData  (wrCountData),
    .str          (str),
    .nextPc       (nextPc),
    .atEnd        (atEnd),
    .countNonZero (countNonZero),
    .loopStart    (loopStart),
    .loopEnd      (loopEnd),
    .loopCount    (loopCount)
  );

  assign loopBack = str.selStart;

endmodule

// File: tb/test_hw_loop_unit.sv
`timescale 1ns/1ps
module test_hw_loop_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] pc = 32'h0;
  logic [2:0]  instLen = 3'd4;
  logic        branchTaken = 1'b0;
  logic [31:0] branchTarget = 32'h0;
  logic        excMode = 1'b0;
  logic        setupValid = 1'b0;
  logic [1:0]  setupKind = 2'd0;
  logic [31:0] setupCount = 32'h0;
  logic [31:0] bodyLen = 32'h0;
  logic        wrStart = 1'b0, wrEnd = 1'b0, wrCount = 1'b0;
  logic [31:0] wrAddr = 32'h0, wrCountData = 32'h0;
  logic [31:0] nextPc, loopStart, loopEnd, loopCount;
  logic        loopBack;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] mStart = 0, mEnd = 0, mCount = 0;
  logic [31:0] lastNext = 0;

  always #2.5 clk = ~clk;

  hw_loop_unit i_hw_loop_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .pc(pc), .instLen(instLen),
    .branchTaken(branchTaken), .branchTarget(branchTarget), .excMode(excMode),
    .setupValid(setupValid), .setupKind(setupKind), .setupCount(setupCount),
    .bodyLen(bodyLen), .wrStart(wrStart), .wrEnd(wrEnd), .wrCount(wrCount),
    .wrAddr(wrAddr), .wrCountData(wrCountData), .nextPc(nextPc),
    .loopBack(loopBack), .loopStart(loopStart), .loopEnd(loopEnd),
    .loopCount(loopCount)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    branchTaken = 0; setupValid = 0; wrStart = 0; wrEnd = 0; wrCount = 0;
    instLen = 3'd4;
  endtask

  // one clock: compare against the reference at negedge, update it at posedge
  task automatic doCycle();
    logic [31:0] seq, expNext;
    logic expBack, skip, doSetup;
    string tag;
    @(negedge clk);
    seq = pc + 32'(instLen);
    expNext = seq; expBack = 0; tag = "R1"; doSetup = 0;
    if (instValid) begin
      if (branchTaken) begin
        expNext = branchTarget; tag = "R5";
      end else if (setupValid) begin
        doSetup = 1;
        skip = (setupKind == 2'd1 && setupCount == 0) ||
               (setupKind == 2'd2 && $signed(setupCount) <= 0);
        if (skip) expNext = seq + bodyLen;
        tag = (setupKind == 2'd2) ? "R8" : (setupKind == 2'd1) ? "R7" : "R2";
      end else if (seq == mEnd) begin
        if (mCount != 0 && !excMode) begin
          expNext = mStart; expBack = 1; tag = "R3";
        end else begin
          tag = excMode ? "R6" : "R4";
        end
      end
    end
    check(tag, "nextPc", nextPc, expNext);
    check(tag, "loopBack", {31'b0, loopBack}, {31'b0, expBack});
    check("R10", "loopStart", loopStart, mStart);
    check("R10", "loopEnd", loopEnd, mEnd);
    check("R9", "loopCount", loopCount, mCount);
    lastNext = expNext;
    @(posedge clk);
    if (wrStart) mStart = wrAddr; else if (doSetup) mStart = seq;
    if (wrEnd) mEnd = wrAddr; else if (doSetup) mEnd = seq + bodyLen;
    if (wrCount) mCount = wrCountData;
    else if (doSetup) mCount = setupCount - 1;
    else if (expBack) mCount = mCount - 1;
    #1;
  endtask

  task automatic setupAt(input logic [31:0] at, input logic [1:0] kind,
                         input logic [31:0] cnt, input logic [31:0] blen);
    idle(); instValid = 1; pc = at;
    setupValid = 1; setupKind = kind; setupCount = cnt; bodyLen = blen;
    doCycle();
    idle(); pc = lastNext;
  endtask

  // run from pc until stopPc, counting visits to bodyPc
  task automatic runTo(input logic [31:0] stopPc, input logic [31:0] bodyPc,
                       output int hits);
    hits = 0; idle(); instValid = 1;
    for (int i = 0; i < 64 && pc != stopPc; i++) begin
      if (pc == bodyPc) hits++;
      doCycle();
      pc = lastNext;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    int hits;
    pc = 32'h100;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1", "reset start", loopStart, 0);
    check("R1", "reset end", loopEnd, 0);
    check("R1", "reset count", loopCount, 0);
    check("R1", "idle nextPc", nextPc, 32'h104);
    @(posedge clk); #1;
    rstN = 1;

    // R2 R3: count 5 runs body 5 times
    setupAt(32'h100, 2'd0, 5, 4);
    check("R2", "start", loopStart, 32'h104);
    check("R2", "end", loopEnd, 32'h108);
    runTo(32'h108, 32'h104, hits);
    check("R3", "body runs N=5", hits, 5);
    check("R3", "count after", loopCount, 0);

    // R4: body again with count zero falls through
    pc = 32'h104; runTo(32'h108, 32'h104, hits);
    check("R4", "zero count single run", hits, 1);

    setupAt(32'h100, 2'd0, 1, 4);
    runTo(32'h108, 32'h104, hits);
    check("R3", "body runs N=1", hits, 1);

    // R2: operand 0 wraps, then R5 branch out
    setupAt(32'h100, 2'd0, 0, 4);
    check("R2", "zero operand wraps", loopCount, 32'hFFFFFFFF);
    for (int i = 0; i < 3; i++) begin idle(); instValid = 1; doCycle(); pc = lastNext; end
    check("R3", "wrapped count decrements", loopCount, 32'hFFFFFFFC);
    idle(); instValid = 1; branchTaken = 1; branchTarget = 32'h200; doCycle();
    check("R5", "branch at end", lastNext, 32'h200);
    check("R5", "count kept", loopCount, 32'hFFFFFFFC);

    // R5: branch out of the body on the first pass
    setupAt(32'h100, 2'd0, 5, 4);
    idle(); instValid = 1; branchTaken = 1; branchTarget = 32'h108; doCycle();
    pc = lastNext;
    check("R5", "branch exits loop", pc, 32'h108);
    check("R5", "count after branch", loopCount, 4);

    // R6: exception mode blocks loop-back
    excMode = 1;
    setupAt(32'h100, 2'd0, 5, 4);
    runTo(32'h108, 32'h104, hits);
    check("R6", "exc body once", hits, 1);
    check("R6", "exc count kept", loopCount, 4);
    excMode = 0;

    // R7: skip-if-zero
    setupAt(32'h100, 2'd1, 0, 4);
    check("R7", "skip to end", pc, 32'h108);
    check("R7", "regs still loaded", loopCount, 32'hFFFFFFFF);
    setupAt(32'h100, 2'd1, 5, 4);
    runTo(32'h108, 32'h104, hits);
    check("R7", "nonzero runs 5", hits, 5);

    // R8: skip-if-not-positive
    setupAt(32'h100, 2'd2, 0, 4);
    check("R8", "zero skips", pc, 32'h108);
    setupAt(32'h100, 2'd2, 32'h80000000, 4);
    check("R8", "most negative skips", pc, 32'h108);
    setupAt(32'h100, 2'd2, 32'hFFFFFFFD, 4);
    check("R8", "negative skips", pc, 32'h108);
    setupAt(32'h100, 2'd2, 2, 4);
    runTo(32'h108, 32'h104, hits);
    check("R8", "positive runs 2", hits, 2);

    // R9: direct writes with instValid low, C+1 executions
    idle(); instValid = 0; wrStart = 1; wrEnd = 1; wrCount = 1;
    wrAddr = 32'h304; wrCountData = 5; doCycle();
    wrAddr = 32'h308; wrStart = 0; wrCount = 0; doCycle();
    pc = 32'h304; runTo(32'h308, 32'h304, hits);
    check("R9", "written count C+1 runs", hits, 6);

    // R9: write wins over decrement and over setup
    setupAt(32'h100, 2'd0, 3, 4);
    idle(); instValid = 1; wrCount = 1; wrCountData = 10; doCycle(); pc = lastNext;
    check("R9", "write beats decrement", loopCount, 10);
    check("R9", "loop-back still taken", pc, 32'h104);
    idle(); instValid = 1; pc = 32'h100; setupValid = 1; setupKind = 0;
    setupCount = 7; bodyLen = 4; wrCount = 1; wrCountData = 2; doCycle();
    check("R9", "write beats setup", loopCount, 2);

    // R10: shrinking end mid-loop ends it
    idle(); instValid = 0; wrStart = 1; wrEnd = 1; wrCount = 1;
    wrAddr = 32'h400; wrCountData = 5; doCycle();
    wrStart = 0; wrCount = 0; wrAddr = 32'h408; doCycle();
    idle(); instValid = 1; pc = 32'h400; wrEnd = 1; wrAddr = 32'h404; doCycle();
    pc = lastNext; runTo(32'h408, 32'h404, hits);
    check("R10", "moved end exits", hits, 1);
    check("R10", "count untouched", loopCount, 5);

    // R10: moving start mid-loop changes loop-back target
    idle(); instValid = 0; wrStart = 1; wrEnd = 1; wrCount = 1;
    wrAddr = 32'h500; wrCountData = 2; doCycle();
    wrStart = 0; wrCount = 0; wrAddr = 32'h508; doCycle();
    idle(); instValid = 1; pc = 32'h500; wrStart = 1; wrAddr = 32'h504; doCycle();
    pc = lastNext; runTo(32'h508, 32'h504, hits);
    check("R10", "new start repeats", hits, 3);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule